// File: doc/BRIEF.md
# Microstep ALU and Register Datapath

This block is the arithmetic and register unit of a microcoded 16-bit processor. A microsequencer outside the block supplies the fields of the current microword. These fields choose an X operand from a twelve-entry register file and a Y operand from the bus receive, address or transmit register, or from a literal. They also give the ALU function, the carry handling and the destination. Each cycle in which `step_en` is high performs one microstep. The result is written to the chosen destination, and the all-ones, carry and overflow flags are updated.

The Y literal is assembled from two 4-bit literal fields. Each 4-bit slice of the operand is enabled or forced to zero by its own bit of the multifunction field. Some destination codes write the register file and one of the auxiliary registers in the same step, so a result can be kept and also sent to the bus path. A second read port on the register file lets the surrounding logic observe any entry.

Top module: `mstep_datapath`

## Requirements
- R1: After reset, every register file entry, the R, A, T and E registers, the loop counter and the three flags read zero.
- R2: With `fclass`=0, `fcode` picks a bitwise function of X and Y: 0 ~X, 1 ~(X|Y), 2 ~X&Y, 3 all zeros, 4 ~(X&Y), 5 ~Y, 6 X^Y, 7 X&~Y, 8 ~X|Y, 9 ~(X^Y), 10 Y, 11 X&Y, 12 all ones, 13 X|~Y, 14 X|Y, 15 X.
- R3: With `fclass`=1, the result is P+Q+cin modulo 2^16, where (P,Q) per `fcode` is: 0 (X,0), 1 (X,Y), 2 (X,~Y), 3 (X,FFFF), 4 (X,X), 5 (0,Y), 6 (0,~Y), 7 (Y,FFFF), 8 (X,X&Y), 9 (X,X|Y), 10 (X&Y,FFFF), 11 (X|Y,0), 12 (X,X&~Y), 13 (X&~Y,FFFF), 14 (X|~Y,0), 15 (X,X|~Y).
- R4: `cctl` sets the carry-in: 0 and 1 give 0, 2 gives 1, 3 gives the stored carry flag. With `cctl`=0 the carry and overflow flags keep their values. With any other value, a step loads them.
- R5: When carry and overflow are loaded, an arithmetic step stores the carry out of bit 15 and two's-complement overflow (P and Q of equal sign, result of the other sign). A logical step clears both flags.
- R6: Every step sets the all-ones flag exactly when all 16 result bits are 1.
- R7: `ysel` chooses Y: 0 R, 1 A, 2 T, 3 literal.
- R8: The literal's nibble i (bits 4i+3..4i) is `lit_lo` for even i and `lit_hi` for odd i when `mfield`[i]=1, and zero otherwise.
- R9: `wdest` chooses the write: 0 none, 1 file, 2 A, 3 T, 4 loop counter, 5 file and A, 6 file and T, 7 file and E. The file entry written is the one named by `xsel`.
- R10: While `step_en` is low, no register or flag changes, except that R may still be loaded.
- R11: `rx_load` loads R from `rx_data` on the next clock edge.
- R12: Selector values 12 to 15 on `xsel` read as zero, and writes to them are dropped. The same values on `rd_sel` also read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Perform one microstep this cycle |
| rx_load | input | 1 | Load R from rx_data |
| rx_data | input | 16 | Data received from the bus |
| xsel | input | 4 | Register file entry for X and the file write |
| fclass | input | 1 | 0 logical, 1 arithmetic |
| fcode | input | 4 | Function within the class |
| cctl | input | 2 | Carry-in source and flag update |
| ysel | input | 2 | Y operand source |
| mfield | input | 4 | Literal nibble enables |
| lit_hi | input | 4 | Literal for odd nibbles |
| lit_lo | input | 4 | Literal for even nibbles |
| wdest | input | 3 | Destination code |
| rd_sel | input | 4 | Observation read select |
| rd_data | output | 16 | Observation read data |
| alu_out | output | 16 | Combinational ALU result |
| r_reg | output | 16 | Receive register |
| a_reg | output | 16 | Address register |
| t_reg | output | 16 | Transmit register |
| e_reg | output | 16 | Instruction register |
| loop_cnt | output | 16 | Loop counter |
| all_ones | output | 1 | All-ones flag |
| carry_flag | output | 1 | Carry flag |
| ovf_flag | output | 1 | Overflow flag |

## Verification
The bench builds the block with its default parameters: 16-bit data, twelve file entries and 4-bit nibbles. These give 4-bit selectors, so the unused codes 12 to 15 can be driven directly and checked as empty. All sixteen functions of each class are swept on operands that mix sign and bit patterns, such as 0x8001 against 0x7FFF. This brings both carry and signed overflow into reach. The 4-bit `mfield` is enough to try single, alternating and full nibble enable patterns on the literal.

// File: rtl/mstep_pkg.sv
package mstep_pkg;
  typedef enum logic [2:0] {
    DST_NONE = 3'd0, DST_FILE = 3'd1, DST_A = 3'd2, DST_T = 3'd3,
    DST_LOOP = 3'd4, DST_FA = 3'd5, DST_FT = 3'd6, DST_FE = 3'd7
  } dest_e;

  typedef enum logic [1:0] {
    YS_R = 2'd0, YS_A = 2'd1, YS_T = 2'd2, YS_LIT = 2'd3
  } ysrc_e;

  typedef enum logic [1:0] {
    CC_HOLD = 2'd0, CC_ZERO = 2'd1, CC_ONE = 2'd2, CC_FLAG = 2'd3
  } cctl_e;
endpackage

// File: rtl/mstep_regfile.sv
module mstep_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 12,
  parameter int XW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [XW-1:0] wsel,
  input  logic [DW-1:0] wdata,
  input  logic [XW-1:0] rsel_a,
  output logic [DW-1:0] rdata_a,
  input  logic [XW-1:0] rsel_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) mem[g] <= '0;
      else if (we && wsel == XW'(g)) mem[g] <= wdata;
    end
  end

  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rsel_a == XW'(i)) rdata_a = mem[i];
      if (rsel_b == XW'(i)) rdata_b = mem[i];
    end
  end
endmodule

// File: rtl/mstep_ysel.sv
module mstep_ysel #(
  parameter int DW  = 16,
  parameter int NIB = 4,
  localparam int NNIB = DW / NIB
) (
  input  logic [1:0]      ysel,
  input  logic [DW-1:0]   r_val,
  input  logic [DW-1:0]   a_val,
  input  logic [DW-1:0]   t_val,
  input  logic [NNIB-1:0] mfield,
  input  logic [NIB-1:0]  lit_hi,
  input  logic [NIB-1:0]  lit_lo,
  output logic [DW-1:0]   y_out
);
  import mstep_pkg::*;
  logic [DW-1:0] lit_word;

  for (genvar g = 0; g < NNIB; g++) begin : g_nib
    if (g % 2 == 1) begin : g_odd
      assign lit_word[g*NIB +: NIB] = mfield[g] ? lit_hi : '0;
    end else begin : g_even
      assign lit_word[g*NIB +: NIB] = mfield[g] ? lit_lo : '0;
    end
  end

  always_comb begin
    unique case (ysrc_e'(ysel))
      YS_R:    y_out = r_val;
      YS_A:    y_out = a_val;
      YS_T:    y_out = t_val;
      default: y_out = lit_word;
    endcase
  end
endmodule

// File: rtl/mstep_alu.sv
module mstep_alu #(
  parameter int DW = 16
) (
  input  logic          fclass,
  input  logic [3:0]    fcode,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          ovf
);
  function automatic logic [DW-1:0] bit_fn(input logic [3:0] c,
                                           input logic [DW-1:0] a,
                                           input logic [DW-1:0] b);
    case (c)
      4'd0:    return ~a;
      4'd1:    return ~(a | b);
      4'd2:    return ~a & b;
      4'd3:    return '0;
      4'd4:    return ~(a & b);
      4'd5:    return ~b;
      4'd6:    return a ^ b;
      4'd7:    return a & ~b;
      4'd8:    return ~a | b;
      4'd9:    return ~(a ^ b);
      4'd10:   return b;
      4'd11:   return a & b;
      4'd12:   return '1;
      4'd13:   return a | ~b;
      4'd14:   return a | b;
      default: return a;
    endcase
  endfunction

  logic [DW-1:0] opp, opq;
  logic [DW:0]   sum;

  always_comb begin
    case (fcode)
      4'd0:    begin opp = x;       opq = '0;      end
      4'd1:    begin opp = x;       opq = y;       end
      4'd2:    begin opp = x;       opq = ~y;      end
      4'd3:    begin opp = x;       opq = '1;      end
      4'd4:    begin opp = x;       opq = x;       end
      4'd5:    begin opp = '0;      opq = y;       end
      4'd6:    begin opp = '0;      opq = ~y;      end
      4'd7:    begin opp = y;       opq = '1;      end
      4'd8:    begin opp = x;       opq = x & y;   end
      4'd9:    begin opp = x;       opq = x | y;   end
      4'd10:   begin opp = x & y;   opq = '1;      end
      4'd11:   begin opp = x | y;   opq = '0;      end
      4'd12:   begin opp = x;       opq = x & ~y;  end
      4'd13:   begin opp = x & ~y;  opq = '1;      end
      4'd14:   begin opp = x | ~y;  opq = '0;      end
      default: begin opp = x;       opq = x | ~y;  end
    endcase
    sum = {1'b0, opp} + {1'b0, opq} + {{DW{1'b0}}, cin};
    if (fclass) begin
      res  = sum[DW-1:0];
      cout = sum[DW];
      ovf  = (opp[DW-1] == opq[DW-1]) && (sum[DW-1] != opp[DW-1]);
    end else begin
      res  = bit_fn(fcode, x, y);
      cout = 1'b0;
      ovf  = 1'b0;
    end
  end
endmodule

// File: rtl/mstep_datapath.sv
module mstep_datapath #(
  parameter int DW   = 16,
  parameter int NREG = 12,
  parameter int NIB  = 4,
  localparam int XW   = $clog2(NREG),
  localparam int NNIB = DW / NIB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_en,
  input  logic            rx_load,
  input  logic [DW-1:0]   rx_data,
  input  logic [XW-1:0]   xsel,
  input  logic            fclass,
  input  logic [3:0]      fcode,
  input  logic [1:0]      cctl,
  input  logic [1:0]      ysel,
  input  logic [NNIB-1:0] mfield,
  input  logic [NIB-1:0]  lit_hi,
  input  logic [NIB-1:0]  lit_lo,
  input  logic [2:0]      wdest,
  input  logic [XW-1:0]   rd_sel,
  output logic [DW-1:0]   rd_data,
  output logic [DW-1:0]   alu_out,
  output logic [DW-1:0]   r_reg,
  output logic [DW-1:0]   a_reg,
  output logic [DW-1:0]   t_reg,
  output logic [DW-1:0]   e_reg,
  output logic [DW-1:0]   loop_cnt,
  output logic            all_ones,
  output logic            carry_flag,
  output logic            ovf_flag
);
  import mstep_pkg::*;

  logic [DW-1:0] x_val, y_val;
  logic          alu_cin, alu_cout, alu_ovf;
  logic          rf_we, a_we, t_we, e_we, lc_we, flags_we;

  always_comb begin
    unique case (cctl_e'(cctl))
      CC_ONE:  alu_cin = 1'b1;
      CC_FLAG: alu_cin = carry_flag;
      default: alu_cin = 1'b0;
    endcase
  end

  always_comb begin
    rf_we = 1'b0; a_we = 1'b0; t_we = 1'b0; e_we = 1'b0; lc_we = 1'b0;
    if (step_en) begin
      unique case (dest_e'(wdest))
        DST_FILE: rf_we = 1'b1;
        DST_A:    a_we  = 1'b1;
        DST_T:    t_we  = 1'b1;
        DST_LOOP: lc_we = 1'b1;
        DST_FA:   begin rf_we = 1'b1; a_we = 1'b1; end
        DST_FT:   begin rf_we = 1'b1; t_we = 1'b1; end
        DST_FE:   begin rf_we = 1'b1; e_we = 1'b1; end
        default:  ;
      endcase
    end
  end

  assign flags_we = step_en && (cctl != 2'(CC_HOLD));

  mstep_regfile #(.DW(DW), .NREG(NREG), .XW(XW)) u_file (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .wsel(xsel), .wdata(alu_out),
    .rsel_a(xsel), .rdata_a(x_val), .rsel_b(rd_sel), .rdata_b(rd_data)
  );

  mstep_ysel #(.DW(DW), .NIB(NIB)) u_ysel (
    .ysel(ysel), .r_val(r_reg), .a_val(a_reg), .t_val(t_reg),
    .mfield(mfield), .lit_hi(lit_hi), .lit_lo(lit_lo), .y_out(y_val)
  );

  mstep_alu #(.DW(DW)) u_alu (
    .fclass(fclass), .fcode(fcode), .x(x_val), .y(y_val), .cin(alu_cin),
    .res(alu_out), .cout(alu_cout), .ovf(alu_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_reg <= '0; a_reg <= '0; t_reg <= '0; e_reg <= '0; loop_cnt <= '0;
      all_ones <= 1'b0; carry_flag <= 1'b0; ovf_flag <= 1'b0;
    end else begin
      if (rx_load) r_reg    <= rx_data;
      if (a_we)    a_reg    <= alu_out;
      if (t_we)    t_reg    <= alu_out;
      if (e_we)    e_reg    <= alu_out;
      if (lc_we)   loop_cnt <= alu_out;
      if (step_en) all_ones <= &alu_out;
      if (flags_we) begin
        carry_flag <= alu_cout;
        ovf_flag   <= alu_ovf;
      end
    end
  end
endmodule

// File: rtl/mstep_checker.sv
module mstep_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step_en,
  input logic          fclass,
  input logic [1:0]    cctl,
  input logic [2:0]    wdest,
  input logic [DW-1:0] alu_out,
  input logic [DW-1:0] a_reg,
  input logic [DW-1:0] t_reg,
  input logic [DW-1:0] e_reg,
  input logic [DW-1:0] loop_cnt,
  input logic          all_ones,
  input logic          carry_flag,
  input logic          ovf_flag
);
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(a_reg) && $stable(t_reg) && $stable(e_reg) &&
                 $stable(loop_cnt) && $stable(carry_flag) && $stable(ovf_flag) &&
                 $stable(all_ones));

  assert_ones_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> all_ones == (&$past(alu_out)));

  assert_flag_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && cctl == 2'd0 |=> $stable(carry_flag) && $stable(ovf_flag));

  assert_logic_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !fclass && cctl != 2'd0 |=> !carry_flag && !ovf_flag);

  assert_a_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && (wdest == 3'd2 || wdest == 3'd5) |=> a_reg == $past(alu_out));

  assert_no_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && wdest == 3'd0 |=> $stable(a_reg) && $stable(t_reg) &&
                                 $stable(e_reg) && $stable(loop_cnt));
endmodule

bind mstep_datapath mstep_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_en(step_en), .fclass(fclass), .cctl(cctl),
  .wdest(wdest), .alu_out(alu_out), .a_reg(a_reg), .t_reg(t_reg),
  .e_reg(e_reg), .loop_cnt(loop_cnt), .all_ones(all_ones),
  .carry_flag(carry_flag), .ovf_flag(ovf_flag)
);

// File: tb/mstep_datapath_bench.sv
module mstep_datapath_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_en = 1'b0, rx_load = 1'b0, fclass = 1'b0;
  logic [15:0] rx_data = '0;
  logic [3:0] xsel = '0, fcode = '0, mfield = '0, lit_hi = '0, lit_lo = '0, rd_sel = '0;
  logic [1:0] cctl = '0, ysel = '0;
  logic [2:0] wdest = '0;
  logic [15:0] rd_data, alu_out, r_reg, a_reg, t_reg, e_reg, loop_cnt;
  logic all_ones, carry_flag, ovf_flag;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  mstep_datapath u_mstep_datapath (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .rx_load(rx_load),
    .rx_data(rx_data), .xsel(xsel), .fclass(fclass), .fcode(fcode),
    .cctl(cctl), .ysel(ysel), .mfield(mfield), .lit_hi(lit_hi),
    .lit_lo(lit_lo), .wdest(wdest), .rd_sel(rd_sel), .rd_data(rd_data),
    .alu_out(alu_out), .r_reg(r_reg), .a_reg(a_reg), .t_reg(t_reg),
    .e_reg(e_reg), .loop_cnt(loop_cnt), .all_ones(all_ones),
    .carry_flag(carry_flag), .ovf_flag(ovf_flag)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_logic(int c, logic [15:0] x, logic [15:0] y);
    logic [15:0] r;
    for (int b = 0; b < 16; b++) begin
      logic xb, yb;
      xb = x[b]; yb = y[b];
      case (c)
        0: r[b] = !xb;          1: r[b] = !xb && !yb;
        2: r[b] = !xb && yb;    3: r[b] = 1'b0;
        4: r[b] = !xb || !yb;   5: r[b] = !yb;
        6: r[b] = xb != yb;     7: r[b] = xb && !yb;
        8: r[b] = !xb || yb;    9: r[b] = xb == yb;
        10: r[b] = yb;          11: r[b] = xb && yb;
        12: r[b] = 1'b1;        13: r[b] = xb || !yb;
        14: r[b] = xb || yb;    default: r[b] = xb;
      endcase
    end
    return r;
  endfunction

  // returns {ovf, carry, result}
  function automatic logic [17:0] ref_arith(int c, logic [15:0] x, logic [15:0] y, int cin);
    int p, q, s;
    logic [15:0] pp, qq;
    case (c)
      0: begin pp = x; qq = 16'h0; end
      1: begin pp = x; qq = y; end
      2: begin pp = x; qq = 16'hFFFF ^ y; end
      3: begin pp = x; qq = 16'hFFFF; end
      4: begin pp = x; qq = x; end
      5: begin pp = 16'h0; qq = y; end
      6: begin pp = 16'h0; qq = 16'hFFFF ^ y; end
      7: begin pp = y; qq = 16'hFFFF; end
      8: begin pp = x; qq = x & y; end
      9: begin pp = x; qq = x | y; end
      10: begin pp = x & y; qq = 16'hFFFF; end
      11: begin pp = x | y; qq = 16'h0; end
      12: begin pp = x; qq = x & (16'hFFFF ^ y); end
      13: begin pp = x & (16'hFFFF ^ y); qq = 16'hFFFF; end
      14: begin pp = x | (16'hFFFF ^ y); qq = 16'h0; end
      default: begin pp = x; qq = x | (16'hFFFF ^ y); end
    endcase
    p = int'(pp); q = int'(qq);
    s = p + q + cin;
    begin
      int sp, sq, ss;
      sp = (p >= 32768) ? p - 65536 : p;
      sq = (q >= 32768) ? q - 65536 : q;
      ss = sp + sq + cin;
      return {(ss > 32767 || ss < -32768), (s >= 65536), 16'(s)};
    end
  endfunction

  task automatic step(int xs, int fc, int fcd, int cc, int ys, int mf,
                      int lh, int ll, int wd);
    @(negedge clk);
    xsel = 4'(xs); fclass = 1'(fc); fcode = 4'(fcd); cctl = 2'(cc);
    ysel = 2'(ys); mfield = 4'(mf); lit_hi = 4'(lh); lit_lo = 4'(ll);
    wdest = 3'(wd); step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
  endtask

  task automatic load_r(logic [15:0] v);
    @(negedge clk);
    rx_data = v; rx_load = 1'b1;
    @(negedge clk);
    rx_load = 1'b0;
  endtask

  task automatic read_file(int idx, output logic [15:0] v);
    rd_sel = 4'(idx);
    #1 v = rd_data;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 a", a_reg, 0); check("R1 t", t_reg, 0); check("R1 e", e_reg, 0);
    check("R1 r", r_reg, 0); check("R1 loop", loop_cnt, 0);
    check("R1 flags", {all_ones, carry_flag, ovf_flag}, 0);
    for (int i = 0; i < 12; i++) begin
      read_file(i, v);
      check("R1 file", v, 0);
    end
  endtask

  task automatic t_rload_ysel();
    load_r(16'h1234);
    check("R11 r load", r_reg, 16'h1234);
    step(0, 0, 10, 0, 0, 0, 0, 0, 2);            // A <= R
    check("R7 y=R to A", a_reg, 16'h1234);
    step(0, 0, 10, 0, 1, 0, 0, 0, 3);            // T <= A
    check("R7 y=A to T", t_reg, 16'h1234);
    load_r(16'h0000);
    step(0, 0, 10, 0, 2, 0, 0, 0, 2);            // A <= T
    check("R7 y=T to A", a_reg, 16'h1234);
  endtask

  task automatic t_literal();
    step(0, 0, 10, 0, 3, 4'b1111, 4'hA, 4'h5, 2);
    check("R8 all nibbles", a_reg, 16'hA5A5);
    step(0, 0, 10, 0, 3, 4'b0101, 4'hA, 4'h5, 3);
    check("R8 even nibbles", t_reg, 16'h0505);
    step(0, 0, 10, 0, 3, 4'b1010, 4'hA, 4'h5, 3);
    check("R8 odd nibbles", t_reg, 16'hA0A0);
    step(0, 0, 10, 0, 3, 4'b0001, 4'hA, 4'h5, 3);
    check("R8 one nibble", t_reg, 16'h0005);
  endtask

  task automatic t_logic();
    logic [15:0] x = 16'hC35A, y = 16'h0FF0;
    load_r(x);
    step(4, 0, 10, 0, 0, 0, 0, 0, 1);            // file[4] <= C35A
    load_r(y);
    step(0, 0, 10, 0, 0, 0, 0, 0, 3);            // T <= 0FF0
    for (int c = 0; c < 16; c++) begin
      step(4, 0, c, 1, 2, 0, 0, 0, 4);
      check("R2 logic result", loop_cnt, ref_logic(c, x, y));
      check("R6 all ones", all_ones, &ref_logic(c, x, y));
      check("R5 logic flags cleared", {carry_flag, ovf_flag}, 0);
    end
  endtask

  task automatic t_arith();
    logic [15:0] x = 16'h8001, y = 16'h7FFF;
    logic [17:0] e;
    load_r(x);
    step(2, 0, 10, 0, 0, 0, 0, 0, 1);            // file[2] <= 8001
    load_r(y);
    step(0, 0, 10, 0, 0, 0, 0, 0, 3);            // T <= 7FFF
    for (int ci = 0; ci < 2; ci++) begin
      for (int c = 0; c < 16; c++) begin
        e = ref_arith(c, x, y, ci);
        step(2, 1, c, ci + 1, 2, 0, 0, 0, 4);
        check("R3 arith result", loop_cnt, e[15:0]);
        check("R5 carry", carry_flag, e[16]);
        check("R5 overflow", ovf_flag, e[17]);
        check("R6 all ones arith", all_ones, &e[15:0]);
      end
    end
  endtask

  task automatic t_carry_ctl();
    load_r(16'h7FFF);
    step(5, 0, 10, 0, 0, 0, 0, 0, 1);            // file[5] <= 7FFF
    step(5, 1, 1, 1, 3, 4'b0001, 0, 1, 4);       // 7FFF + 0001
    check("R5 signed overflow sum", loop_cnt, 16'h8000);
    check("R5 signed overflow flags", {carry_flag, ovf_flag}, 2'b01);
    step(6, 0, 12, 0, 0, 0, 0, 0, 1);            // file[6] <= FFFF
    step(6, 1, 0, 2, 0, 0, 0, 0, 4);             // FFFF + 0 + 1
    check("R4 cin one", loop_cnt, 16'h0000);
    check("R4 carry set", {carry_flag, ovf_flag}, 2'b10);
    step(5, 1, 0, 3, 0, 0, 0, 0, 4);             // 7FFF + 0 + carry
    check("R4 cin from flag", loop_cnt, 16'h8000);
    check("R4 flag cin flags", {carry_flag, ovf_flag}, 2'b01);
    step(6, 1, 0, 2, 0, 0, 0, 0, 4);             // carry back to 1
    step(5, 1, 1, 0, 3, 4'b0001, 0, 1, 4);       // hold: 7FFF + 1, cin 0
    check("R4 hold result", loop_cnt, 16'h8000);
    check("R4 hold flags", {carry_flag, ovf_flag}, 2'b10);
  endtask

  task automatic t_dual_dest();
    logic [15:0] v;
    load_r(16'hBEEF);
    step(7, 0, 10, 0, 0, 0, 0, 0, 5);
    read_file(7, v);
    check("R9 dest 5 file", v, 16'hBEEF);
    check("R9 dest 5 A", a_reg, 16'hBEEF);
    load_r(16'h4321);
    step(8, 0, 10, 0, 0, 0, 0, 0, 6);
    read_file(8, v);
    check("R9 dest 6 file", v, 16'h4321);
    check("R9 dest 6 T", t_reg, 16'h4321);
    load_r(16'h9C3E);
    step(9, 0, 10, 0, 0, 0, 0, 0, 7);
    read_file(9, v);
    check("R9 dest 7 file", v, 16'h9C3E);
    check("R9 dest 7 E", e_reg, 16'h9C3E);
    check("R9 dest 7 A untouched", a_reg, 16'hBEEF);
    step(9, 0, 15, 0, 0, 0, 0, 0, 0);
    check("R9 dest 0 loop kept", loop_cnt, 16'h8000);
  endtask

  task automatic t_bad_sel();
    logic [15:0] v;
    load_r(16'h5555);
    step(13, 0, 10, 0, 0, 0, 0, 0, 1);           // write to 13 dropped
    read_file(13, v);
    check("R12 read 13", v, 0);
    step(13, 0, 15, 0, 0, 0, 0, 0, 2);           // A <= X of entry 13
    check("R12 X of 13 zero", a_reg, 0);
    for (int i = 0; i < 12; i++) begin
      read_file(i, v);
      check("R12 no alias", (v == 16'h5555), 0);
    end
  endtask

  task automatic t_idle();
    logic [15:0] a0, t0, lc0;
    a0 = a_reg; t0 = t_reg; lc0 = loop_cnt;
    @(negedge clk);
    xsel = 4'd7; fclass = 1'b0; fcode = 4'd12; cctl = 2'd2; ysel = 2'd0;
    wdest = 3'd4; step_en = 1'b0;
    @(negedge clk);
    wdest = 3'd2;
    @(negedge clk);
    check("R10 loop held", loop_cnt, lc0);
    check("R10 A held", a_reg, a0);
    check("R10 T held", t_reg, t0);
    check("R10 ones held", all_ones, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rload_ysel();
    t_literal();
    t_logic();
    t_arith();
    t_carry_ctl();
    t_dual_dest();
    t_bad_sel();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R10: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule